// File: doc/BRIEF.md
# Multi-Panel Flash Row Write Stager

This block collects code-memory write data for a flash array that is split into panels, each with its own eight-byte row buffer. Software-visible writes arrive one byte at a time through a 22-bit pointer. The pointer fields are decoded as follows:
- the low bits pick the byte within a row,
- the middle bits give the row offset inside a panel,
- the high bits name the panel.

When a commit strobe arrives, the staged rows are handed to the programming engine as one wide word. The word carries the row offset shared by all panels and an enable bit for each panel.

In multi-panel mode every panel is programmed by the same commit, at the same offset, so two panels yield sixteen bytes per programming sequence. With the mode off, only the panel named by the pointer at commit time is enabled.

The offset seen by the first load after a commit is remembered. A commit whose pointer offset differs from it is refused with an error pulse. Every commit, accepted or refused, returns all buffers to the erased value 0xFF.

Top module: `flash_row_stager`

## Requirements
- R1: The pointer is decoded as byte index = bits [2:0], row offset = bits [12:3], panel = bits [21:13]. Byte i of panel p appears on `pr_data[p*64 + i*8 +: 8]`.
- R2: A load with `ld_strobe` high writes `ld_byte` into the addressed byte. A later load to the same byte before a commit replaces it.
- R3: Every byte not loaded since the last commit or reset reads out as 0xFF.
- R4: With `multi_en` high at commit, `pr_valid` is high for one cycle in the cycle after the commit strobe. All bits of `pr_en` are set, and `pr_data` holds every panel's row.
- R5: With `multi_en` low at commit, `pr_en` has exactly one bit set, the panel named by pointer bits [21:13]. A panel number not below NUM_PANELS gives no request and no error.
- R6: `pr_offset` equals pointer bits [12:3] sampled at the commit strobe.
- R7: If a byte was loaded since the last commit and pointer bits [12:3] at commit differ from their value at the first such load, `offset_err` pulses for one cycle and `pr_valid` stays low.
- R8: All buffers return to 0xFF after every commit, whether accepted or refused. A commit with nothing loaded is accepted with all-0xFF data and no error.
- R9: A load in the same cycle as a commit, or one whose panel number is not below NUM_PANELS, changes no buffer and does not capture an offset.
- R10: After reset `pr_valid` and `offset_err` are low, and all bytes read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_addr | input | 22 | Pointer used by loads and by commit |
| ld_strobe | input | 1 | Load the byte at `ptr_addr` |
| ld_byte | input | 8 | Byte to load |
| multi_en | input | 1 | Commit all panels together |
| commit | input | 1 | Start a programming request |
| pr_valid | output | 1 | One-cycle programming request |
| pr_offset | output | 10 | Row offset shared by the enabled panels |
| pr_en | output | NUM_PANELS | Per-panel program enable |
| pr_data | output | NUM_PANELS*64 | Row data of all panels |
| offset_err | output | 1 | One-cycle pulse when a commit is refused |

## Verification
The assertions assume that `multi_en` and `ptr_addr` are stable during the commit cycle. They also assume that the bench reads `pr_offset`, `pr_en` and `pr_data` only while `pr_valid` is high. The stimulus drives every input at the falling edge and holds it for a full cycle, so the block never sees a change at its sampling edge. Commits are single-cycle pulses separated by at least one idle cycle, matching the one-cycle request and error pulses the properties expect. One directed case drives a load and a commit together to exercise the priority rule.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
    localparam int ADDR_W    = 22;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 3;
    localparam int OFS_W     = 10;
    localparam int PNL_W     = ADDR_W - OFS_W - IDX_W;
    localparam int ROW_BYTES = 1 << IDX_W;
    localparam int ROW_W     = ROW_BYTES * BYTE_W;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [PNL_W-1:0] pnl_t;

    // pointer layout: panel high, row offset middle, byte index low
    typedef struct packed {
        pnl_t panel;
        ofs_t ofs;
        idx_t idx;
    } ptr_t;

    function automatic logic [BYTE_W-1:0] erased_byte();
        return {BYTE_W{1'b1}};
    endfunction
endpackage

// File: rtl/panel_buffer.sv
module panel_buffer
    import fbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  idx_t              wr_idx,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              clear,
    output logic [ROW_W-1:0]  row
);
    logic [ROW_BYTES-1:0] vld;
    logic [BYTE_W-1:0]    mem [ROW_BYTES];

    always_ff @(posedge clk) begin
        if (rst || clear) vld <= '0;
        else if (wr_en)   vld[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_byte;
    end

    always_comb begin
        for (int i = 0; i < ROW_BYTES; i++)
            row[i*BYTE_W +: BYTE_W] = vld[i] ? mem[i] : erased_byte();
    end

    // R8
    cleared_row_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && !wr_en) |=> (row == {ROW_W{1'b1}}));
endmodule

// File: rtl/offset_tracker.sv
module offset_tracker
    import fbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  ofs_t ld_ofs,
    input  logic clear,
    input  ofs_t cmp_ofs,
    output logic mismatch
);
    logic armed;
    ofs_t held;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed <= 1'b0;
            held  <= '0;
        end else if (ld && !armed) begin
            armed <= 1'b1;
            held  <= ld_ofs;
        end
    end

    assign mismatch = armed && (cmp_ofs != held);

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(armed) && armed) |-> $stable(held));
endmodule

// File: rtl/flash_row_stager.sv
module flash_row_stager
    import fbuf_pkg::*;
#(
    parameter int NUM_PANELS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           ptr_addr,
    input  logic                        ld_strobe,
    input  logic [BYTE_W-1:0]           ld_byte,
    input  logic                        multi_en,
    input  logic                        commit,
    output logic                        pr_valid,
    output logic [OFS_W-1:0]            pr_offset,
    output logic [NUM_PANELS-1:0]       pr_en,
    output logic [NUM_PANELS*ROW_W-1:0] pr_data,
    output logic                        offset_err
);
    localparam int DATA_W = NUM_PANELS * ROW_W;

    ptr_t                  cur;
    logic                  in_range;
    logic                  ld_acc;
    logic                  mism;
    logic [NUM_PANELS-1:0] sel_en;
    logic [DATA_W-1:0]     rows;

    assign cur      = ptr_t'(ptr_addr);
    assign in_range = (32'(cur.panel) < NUM_PANELS);
    assign ld_acc   = ld_strobe && !commit && in_range;

    for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
        panel_buffer u_buf (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (ld_acc && (cur.panel == PNL_W'(p))),
            .wr_idx  (cur.idx),
            .wr_byte (ld_byte),
            .clear   (commit),
            .row     (rows[p*ROW_W +: ROW_W])
        );
    end

    offset_tracker u_ofs (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld_acc),
        .ld_ofs   (cur.ofs),
        .clear    (commit),
        .cmp_ofs  (cur.ofs),
        .mismatch (mism)
    );

    always_comb begin
        for (int p = 0; p < NUM_PANELS; p++)
            sel_en[p] = multi_en || (cur.panel == PNL_W'(p));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pr_valid   <= 1'b0;
            offset_err <= 1'b0;
            pr_offset  <= '0;
            pr_en      <= '0;
            pr_data    <= '1;
        end else begin
            pr_valid   <= commit && !mism && (|sel_en);
            offset_err <= commit && mism;
            if (commit) begin
                pr_offset <= cur.ofs;
                pr_en     <= sel_en;
                pr_data   <= rows;
            end
        end
    end

    // R7
    no_dual_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !(pr_valid && offset_err));

    // R4
    multi_all_en_chk: assert property (@(posedge clk) disable iff (rst)
        (pr_valid && $past(multi_en)) |-> (&pr_en));

    // R5
    single_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (pr_valid && !$past(multi_en)) |-> ($countones(pr_en) == 1));

    // R6
    offset_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pr_valid |-> (pr_offset == $past(cur.ofs)));

    // R4
    pulse_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (pr_valid || offset_err) |-> $past(commit));
endmodule

// File: tb/flash_row_stager_test.sv
module flash_row_stager_test;
    import fbuf_pkg::*;

    localparam int NP = 2;
    localparam int DW = NP * ROW_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] ptr_addr = '0;
    logic              ld_strobe = 1'b0;
    logic [7:0]        ld_byte = '0;
    logic              multi_en = 1'b0;
    logic              commit = 1'b0;
    logic              pr_valid;
    logic [OFS_W-1:0]  pr_offset;
    logic [NP-1:0]     pr_en;
    logic [DW-1:0]     pr_data;
    logic              offset_err;

    flash_row_stager #(.NUM_PANELS(NP)) uut (
        .clk(clk), .rst(rst), .ptr_addr(ptr_addr), .ld_strobe(ld_strobe),
        .ld_byte(ld_byte), .multi_en(multi_en), .commit(commit),
        .pr_valid(pr_valid), .pr_offset(pr_offset), .pr_en(pr_en),
        .pr_data(pr_data), .offset_err(offset_err)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] model [NP][ROW_BYTES];

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic logic [ADDR_W-1:0] mk(int pnl, logic [9:0] ofs, int idx);
        return {9'(pnl), ofs, 3'(idx)};
    endfunction

    function automatic logic [DW-1:0] model_flat();
        logic [DW-1:0] v;
        for (int p = 0; p < NP; p++)
            for (int i = 0; i < ROW_BYTES; i++)
                v[p*64 + i*8 +: 8] = model[p][i];
        return v;
    endfunction

    task automatic model_clear();
        for (int p = 0; p < NP; p++)
            for (int i = 0; i < ROW_BYTES; i++)
                model[p][i] = 8'hFF;
    endtask

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ptr_addr  = a;
        ld_byte   = d;
        ld_strobe = 1'b1;
        @(negedge clk);
        ld_strobe = 1'b0;
    endtask

    task automatic do_commit(input logic m, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        multi_en = m;
        ptr_addr = a;
        commit   = 1'b1;
        @(negedge clk);
        commit   = 1'b0;
    endtask

    typedef struct packed {
        logic       multi;
        logic [3:0] sel;
        logic [9:0] ofs;
        logic [3:0] nbytes;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t TBL [5] = '{
        '{1'b1, 4'd0, 10'h005, 4'd8, 8'h10},
        '{1'b1, 4'd1, 10'h3FF, 4'd3, 8'h40},
        '{1'b0, 4'd1, 10'h000, 4'd8, 8'hA0},
        '{1'b0, 4'd0, 10'h155, 4'd5, 8'h33},
        '{1'b1, 4'd0, 10'h2AA, 4'd0, 8'h00}
    };

    initial begin
        logic [NP-1:0] exp_en;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(pr_valid == 1'b0 && offset_err == 1'b0, "R10 reset outputs",
            DW'({pr_valid, offset_err}), '0);

        // table-driven commits: R1 R2 R3 R4 R5 R6
        for (int t = 0; t < 5; t++) begin
            vec_t v = TBL[t];
            for (int p = 0; p < NP; p++) begin
                if (v.multi || p == int'(v.sel)) begin
                    for (int i = int'(v.nbytes) - 1; i >= 0; i--) begin
                        logic [7:0] d = 8'(int'(v.seed) + p*16 + i);
                        do_load(mk(p, v.ofs, i), d);
                        model[p][i] = d;
                    end
                end
            end
            do_commit(v.multi, mk(int'(v.sel), v.ofs, 0));
            exp_en = v.multi ? '1 : NP'(1 << v.sel);
            chk(pr_valid && !offset_err, "R4 request pulse",
                DW'({pr_valid, offset_err}), DW'(2'b10));
            chk(pr_en == exp_en, "R5 panel enables", DW'(pr_en), DW'(exp_en));
            chk(pr_offset == v.ofs, "R6 offset", DW'(pr_offset), DW'(v.ofs));
            chk(pr_data == model_flat(), "R1 R3 row data", pr_data, model_flat());
            model_clear();
            @(negedge clk);
            chk(!pr_valid, "R4 single-cycle pulse", DW'(pr_valid), '0);
        end

        // R2 overwrite
        do_load(mk(0, 10'h011, 2), 8'h11);
        do_load(mk(0, 10'h011, 2), 8'h22);
        model[0][2] = 8'h22;
        do_commit(1'b0, mk(0, 10'h011, 0));
        chk(pr_valid && pr_data == model_flat(), "R2 overwrite", pr_data, model_flat());
        model_clear();

        // R7 offset mismatch
        do_load(mk(1, 10'h007, 4), 8'h5C);
        do_commit(1'b1, mk(1, 10'h008, 0));
        chk(offset_err && !pr_valid, "R7 refused commit",
            DW'({pr_valid, offset_err}), DW'(2'b01));
        @(negedge clk);
        chk(!offset_err, "R7 error single pulse", DW'(offset_err), '0);

        // R8 cleared after refused commit; empty commit accepted
        do_commit(1'b1, mk(0, 10'h009, 0));
        chk(pr_valid && !offset_err && pr_data == {DW{1'b1}}, "R8 empty commit",
            pr_data, {DW{1'b1}});

        // R9 load coincident with commit is dropped
        @(negedge clk);
        multi_en  = 1'b1;
        ptr_addr  = mk(0, 10'h020, 0);
        ld_byte   = 8'h5A;
        ld_strobe = 1'b1;
        commit    = 1'b1;
        @(negedge clk);
        ld_strobe = 1'b0;
        commit    = 1'b0;
        do_commit(1'b1, mk(0, 10'h030, 0));
        chk(pr_valid && !offset_err && pr_data == {DW{1'b1}}, "R9 load during commit",
            pr_data, {DW{1'b1}});

        // R9 out-of-range panel load ignored
        do_load(mk(2, 10'h040, 1), 8'h77);
        do_commit(1'b1, mk(0, 10'h041, 0));
        chk(pr_valid && !offset_err && pr_data == {DW{1'b1}}, "R9 out-of-range load",
            pr_data, {DW{1'b1}});

        // R5 single-mode commit to a missing panel
        do_commit(1'b0, mk(3, 10'h000, 0));
        chk(!pr_valid && !offset_err, "R5 missing panel",
            DW'({pr_valid, offset_err}), '0);

        // R10 reset clears staged bytes
        do_load(mk(1, 10'h050, 6), 8'h99);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!pr_valid && !offset_err, "R10 outputs after reset",
            DW'({pr_valid, offset_err}), '0);
        do_commit(1'b1, mk(0, 10'h051, 0));
        chk(pr_valid && !offset_err && pr_data == {DW{1'b1}}, "R10 buffers erased",
            pr_data, {DW{1'b1}});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule